// File: doc/BRIEF.md
# SDRAM and Boot-Memory Controller

This block serves a single requester with 4-word bursts and steers each request to one of two memories behind it. Two address windows, each described by a start and a size, are decoded from the request. The main window is backed by SDRAM. The boot window is backed by a parallel PROM or flash device whose data lines share the SDRAM data pins.

A write burst is captured whole into a 4-word write buffer before any memory command is issued. Read bursts are collected in a 4-word prefetch buffer and returned in one response cycle.

SDRAM accesses use a closed-page policy: activate, one column command with burst length 4, then precharge of all banks. RAS-to-CAS delay and CAS latency are chosen at run time. An interval counter schedules auto-refresh. Before each refresh, all banks are precharged.

Boot-memory accesses are strobed with a programmable number of wait states. While a boot access is in progress, the SDRAM stays deselected. A write-protect control turns writes into the boot window into error responses.

Top module: `sdboot_memctl`

## Requirements
- R1: After reset, `req_ready` stays low until a fixed init sequence has run: a precharge-all, two auto-refreshes, then a mode-register load whose `sd_addr[2:0]` is 3'b010 (burst of 4) and whose `sd_addr[6:4]` is the CAS latency.
- R2: `req_addr` is a burst index, so the word address is `{req_addr,2'b00}`. A word address hits the main window when its offset from `cfg_base_start` is below both `cfg_base_size` and 8M words (32 MB). It hits the boot window when its offset from `cfg_boot_start` is below both `cfg_boot_size` and 2M words (8 MB). The main window wins where the two overlap. A request that hits neither window returns `rsp_err`=1 and issues no memory command.
- R3: The distance from an activate command to its read or write command equals the RAS-to-CAS delay. `cfg_rcd` 0, 1 and 2 or 3 select 2, 3 and 4 cycles.
- R4: `cfg_cl` 0 or 1 selects a CAS latency of 2 or 3. Data for beat k is taken from `dq_in` CL+1+k edges after the read command's edge. The response places word k in `rsp_rdata[32k+31:32k]`.
- R5: A write burst drives its four words on `dq_out` with `dq_oe` high. Word 0 is driven with the write command and the others on the three following cycles. `req_be[4k+b]`=1 enables byte b of word k, and it is driven as `sd_dqm`=~`req_be[4k+3:4k]`.
- R6: Every SDRAM burst ends with a precharge-all. Every request gets exactly one `rsp_valid` pulse that lasts a single cycle.
- R7: A refresh becomes pending every `cfg_ref_int` cycles. It is served ahead of a new request once the current burst has finished. Each auto-refresh command follows a precharge-all with no activate in between.
- R8: A boot access holds `rom_ce_n` low and drives the word offset into the window on `rom_addr`. The read or write strobe stays low for `cfg_boot_wait`+1 cycles per word, and `sd_cs_n` stays high throughout.
- R9: While `cfg_boot_wp`=1, a write that hits the boot window returns `rsp_err`=1 and produces no `rom_we_n` strobe. Reads of the boot window still complete.
- R10: `dq_oe` is never high while `rom_oe_n` is low, so only one device drives the shared data bus at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rcd | input | 2 | RAS-to-CAS delay select |
| cfg_cl | input | 1 | CAS latency select |
| cfg_ref_int | input | 16 | Refresh interval in cycles |
| cfg_base_start | input | 24 | Main window start (word address) |
| cfg_base_size | input | 24 | Main window size in words |
| cfg_boot_start | input | 24 | Boot window start (word address) |
| cfg_boot_size | input | 24 | Boot window size in words |
| cfg_boot_wp | input | 1 | Boot window write protect |
| cfg_boot_wait | input | 4 | Boot access wait states |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write burst |
| req_addr | input | 22 | Burst index (word address / 4) |
| req_be | input | 16 | Byte enables of the burst |
| req_wdata | input | 128 | Write burst data, word 0 in low bits |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 128 | Read burst data |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank |
| sd_addr | output | 12 | SDRAM address |
| sd_dqm | output | 4 | Byte masks, shared by both devices |
| rom_ce_n | output | 1 | Boot device chip enable |
| rom_oe_n | output | 1 | Boot device output enable |
| rom_we_n | output | 1 | Boot device write strobe |
| rom_addr | output | 21 | Boot device word address |
| dq_out | output | 32 | Shared data bus, driven value |
| dq_oe | output | 1 | Shared data bus drive enable |
| dq_in | input | 32 | Shared data bus, received value |

## Verification
The bench models the SDRAM and the boot device. Its SDRAM model returns data only in the exact cycles that the programmed CAS latency allows and places filler on the bus at every other time. Because of that, the read tests are run under three delay and latency pairings: a latency off by one cycle corrupts the data, and the measured activate-to-column gap shows whether the delay was applied.

Write bursts use a sparse byte-enable pattern against preloaded words, which separates correct byte merging from whole-word writes. Boot reads under two wait-state counts separate a fixed strobe width from a programmed one.

The error cases are checked by counting memory strobes around each rejected request:
- a request just past the 32 MB cap,
- a request outside both windows,
- a write to the protected boot window.

A short refresh interval checks the refresh rate and that every refresh follows a precharge-all.

// File: rtl/sdboot_memctl.sv
module sdboot_memctl #(
  parameter int AW       = 24,
  parameter int DW       = 32,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 9,
  parameter int ROM_AW   = 21,
  parameter int WS_W     = 4,
  parameter int REF_W    = 16,
  parameter int TRP      = 2,
  parameter int TRFC     = 6,
  parameter int TWR      = 2,
  parameter int INIT_CYC = 8,
  parameter int BASE_MAX = 1 << 23,
  parameter int BOOT_MAX = 1 << 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_rcd,
  input  logic               cfg_cl,
  input  logic [REF_W-1:0]   cfg_ref_int,
  input  logic [AW-1:0]      cfg_base_start,
  input  logic [AW-1:0]      cfg_base_size,
  input  logic [AW-1:0]      cfg_boot_start,
  input  logic [AW-1:0]      cfg_boot_size,
  input  logic               cfg_boot_wp,
  input  logic [WS_W-1:0]    cfg_boot_wait,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-3:0]      req_addr,
  input  logic [4*DW/8-1:0]  req_be,
  input  logic [4*DW-1:0]    req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [4*DW-1:0]    rsp_rdata,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [1:0]         sd_ba,
  output logic [ROW_W-1:0]   sd_addr,
  output logic [DW/8-1:0]    sd_dqm,
  output logic               rom_ce_n,
  output logic               rom_oe_n,
  output logic               rom_we_n,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [DW-1:0]      dq_out,
  output logic               dq_oe,
  input  logic [DW-1:0]      dq_in
);
  localparam int DMW = DW / 8;
  localparam int SDW = COL_W + ROW_W + 2;
  localparam int CW  = 8;
  localparam logic [3:0] CMD_DES = 4'b1111, CMD_ACT = 4'b0011, CMD_RD  = 4'b0101,
                         CMD_WR  = 4'b0100, CMD_PRE = 4'b0010, CMD_REF = 4'b0001,
                         CMD_MRS = 4'b0000;
  localparam logic [ROW_W-1:0] PRE_ALL = ROW_W'(1 << 10);

  typedef enum logic [3:0] {S_INIT, S_IDLE, S_RCD, S_RDAT, S_WDAT, S_WREC,
                            S_PRE, S_PWAIT, S_RWAIT, S_ROM, S_RSP} st_t;
  st_t st;

  logic [CW-1:0]     cnt;
  logic [2:0]        istep;
  logic [1:0]        beat;
  logic              wr_q;
  logic [4*DMW-1:0]  be_q;
  logic [4*DW-1:0]   wd_q;
  logic [SDW-1:0]    off_q;
  logic [3:0]        cmd_q;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_pend;

  logic [AW-1:0] req_a, base_off, boot_off;
  logic          base_hit, boot_ok, ref_hit, ref_issue;
  logic [2:0]    rcd_n, cl_n;
  logic [CW-1:0] wait1;
  logic [1:0]    beat_n;

  assign req_a     = {req_addr, 2'b00};
  assign base_off  = req_a - cfg_base_start;
  assign boot_off  = req_a - cfg_boot_start;
  assign base_hit  = req_a >= cfg_base_start && base_off < cfg_base_size && base_off < AW'(BASE_MAX);
  assign boot_ok   = req_a >= cfg_boot_start && boot_off < cfg_boot_size && boot_off < AW'(BOOT_MAX)
                     && !(req_write && cfg_boot_wp);
  assign rcd_n     = (cfg_rcd == 2'd0) ? 3'd2 : (cfg_rcd == 2'd1) ? 3'd3 : 3'd4;
  assign cl_n      = cfg_cl ? 3'd3 : 3'd2;
  assign wait1     = CW'(cfg_boot_wait) + CW'(1);
  assign beat_n    = beat + 2'd1;
  assign ref_hit   = (st != S_INIT) && (ref_cnt >= cfg_ref_int - REF_W'(1));
  assign ref_issue = (st == S_RWAIT) && (cnt <= CW'(1));
  assign req_ready = (st == S_IDLE) && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_INIT; cnt <= CW'(INIT_CYC); istep <= '0; beat <= '0;
      wr_q <= 1'b0; be_q <= '0; wd_q <= '0; off_q <= '0; cmd_q <= CMD_DES;
      sd_ba <= '0; sd_addr <= '0; sd_dqm <= '0; dq_out <= '0; dq_oe <= 1'b0;
      rom_ce_n <= 1'b1; rom_oe_n <= 1'b1; rom_we_n <= 1'b1; rom_addr <= '0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
      ref_cnt <= '0; ref_pend <= 1'b0;
    end else begin
      cmd_q     <= CMD_DES;
      rsp_valid <= 1'b0;
      if (st != S_INIT) ref_cnt <= ref_hit ? '0 : ref_cnt + REF_W'(1);
      ref_pend <= (ref_pend && !ref_issue) || ref_hit;
      case (st)
        S_INIT: if (cnt > CW'(1)) cnt <= cnt - CW'(1);
          else begin
            istep <= istep + 3'd1;
            case (istep)
              3'd0:      begin cmd_q <= CMD_PRE; sd_addr <= PRE_ALL; cnt <= CW'(TRP); end
              3'd1,3'd2: begin cmd_q <= CMD_REF; cnt <= CW'(TRFC); end
              3'd3:      begin cmd_q <= CMD_MRS; sd_addr <= ROW_W'({cl_n, 1'b0, 3'b010}); cnt <= CW'(2); end
              default:   st <= S_IDLE;
            endcase
          end
        S_IDLE: if (ref_pend) begin
            cmd_q <= CMD_PRE; sd_addr <= PRE_ALL; cnt <= CW'(TRP); st <= S_RWAIT;
          end else if (req_valid) begin
            wr_q <= req_write; be_q <= req_be; wd_q <= req_wdata; beat <= '0; rsp_err <= 1'b0;
            if (base_hit) begin
              cmd_q <= CMD_ACT; sd_ba <= base_off[SDW-1 -: 2]; sd_addr <= base_off[COL_W +: ROW_W];
              off_q <= base_off[SDW-1:0]; cnt <= CW'(rcd_n); st <= S_RCD;
            end else if (boot_ok) begin
              rom_ce_n <= 1'b0; rom_oe_n <= req_write; rom_we_n <= !req_write;
              rom_addr <= boot_off[ROM_AW-1:0]; dq_out <= req_wdata[DW-1:0]; dq_oe <= req_write;
              sd_dqm <= req_write ? ~req_be[DMW-1:0] : '0; cnt <= wait1; st <= S_ROM;
            end else begin
              rsp_err <= 1'b1; st <= S_RSP;
            end
          end
        S_RCD: if (cnt > CW'(1)) cnt <= cnt - CW'(1);
          else begin
            cmd_q <= wr_q ? CMD_WR : CMD_RD; sd_addr <= ROW_W'(off_q[COL_W-1:0]);
            if (wr_q) begin
              dq_out <= wd_q[DW-1:0]; dq_oe <= 1'b1; sd_dqm <= ~be_q[DMW-1:0];
              beat <= 2'd1; st <= S_WDAT;
            end else begin
              cnt <= CW'(cl_n) + CW'(1); st <= S_RDAT;
            end
          end
        S_WDAT: begin
          dq_out <= wd_q[int'(beat)*DW +: DW]; sd_dqm <= ~be_q[int'(beat)*DMW +: DMW];
          beat <= beat_n;
          if (beat == 2'd3) begin cnt <= CW'(TWR); st <= S_WREC; end
        end
        S_WREC: begin
          dq_oe <= 1'b0; sd_dqm <= '0;
          if (cnt > CW'(1)) cnt <= cnt - CW'(1); else st <= S_PRE;
        end
        S_RDAT: if (cnt > CW'(1)) cnt <= cnt - CW'(1);
          else begin
            rsp_rdata[int'(beat)*DW +: DW] <= dq_in; beat <= beat_n;
            if (beat == 2'd3) st <= S_PRE;
          end
        S_PRE: begin
          cmd_q <= CMD_PRE; sd_addr <= PRE_ALL; rsp_valid <= 1'b1; cnt <= CW'(TRP); st <= S_PWAIT;
        end
        S_PWAIT: if (cnt > CW'(1)) cnt <= cnt - CW'(1); else st <= S_IDLE;
        S_RWAIT: if (cnt > CW'(1)) cnt <= cnt - CW'(1);
          else begin cmd_q <= CMD_REF; cnt <= CW'(TRFC); st <= S_PWAIT; end
        S_ROM: if (cnt > CW'(1)) cnt <= cnt - CW'(1);
          else begin
            if (!wr_q) rsp_rdata[int'(beat)*DW +: DW] <= dq_in;
            if (beat == 2'd3) begin
              rom_ce_n <= 1'b1; rom_oe_n <= 1'b1; rom_we_n <= 1'b1;
              dq_oe <= 1'b0; sd_dqm <= '0; st <= S_RSP;
            end else begin
              beat <= beat_n; rom_addr <= rom_addr + ROM_AW'(1); cnt <= wait1;
              dq_out <= wd_q[int'(beat_n)*DW +: DW];
              sd_dqm <= wr_q ? ~be_q[int'(beat_n)*DMW +: DMW] : '0;
            end
          end
        S_RSP: begin rsp_valid <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic pre_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_seen <= 1'b0;
    else if (cmd_q == CMD_PRE && sd_addr[10]) pre_seen <= 1'b1;
    else if (cmd_q == CMD_ACT) pre_seen <= 1'b0;
  end

  AST_REF_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> pre_seen); // R7
  AST_BOOT_SD_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> sd_cs_n); // R8
  AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_we_n) |-> !cfg_boot_wp); // R9
  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !dq_oe); // R10
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
endmodule

// File: tb/sdboot_memctl_tb_top.sv
module sdboot_memctl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [1:0]  cfg_rcd = 2'd0;
  logic        cfg_cl = 1'b0;
  logic [15:0] cfg_ref_int = 16'd3000;
  logic [23:0] cfg_base_start = 24'h100000, cfg_base_size = 24'h400000;
  logic [23:0] cfg_boot_start = 24'h800000, cfg_boot_size = 24'h040000;
  logic        cfg_boot_wp = 1'b0;
  logic [3:0]  cfg_boot_wait = 4'd1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_be = '0;
  logic [127:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [127:0] rsp_rdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  logic [3:0] sd_dqm;
  logic rom_ce_n, rom_oe_n, rom_we_n;
  logic [20:0] rom_addr;
  logic [31:0] dq_out, dq_in;
  logic dq_oe;

  sdboot_memctl dut_i (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [31:0] sdm [int];
  logic [31:0] rom [int];
  logic [11:0] open_row [4];
  int act_cyc = 0, last_rcd = 0, rd_cyc = -1000, wr_cyc = -1000, rd_base = 0, wr_base = 0;
  int exp_cl = 2, refs = 0, ref_bad = 0, acts = 0, oe_low = 0, we_low = 0;
  int cs_viol = 0, bus_fight = 0;
  bit pre_all = 0;
  logic [11:0] mrs_val = '0;

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] keep_n);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (!keep_n[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] sd_rd(int a);
    return sdm.exists(a) ? sdm[a] : 32'h0;
  endfunction

  function automatic logic [31:0] rom_rd(int a);
    return rom.exists(a) ? rom[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    logic [31:0] drv;
    drv = 32'hBAD0_0000 | 32'(cyc);
    if (rst_n) begin
      case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
        4'b0011: begin open_row[sd_ba] = sd_addr; act_cyc = cyc; acts++; pre_all = 0; end
        4'b0101: begin last_rcd = cyc - act_cyc; rd_cyc = cyc; rd_base = int'({sd_ba, open_row[sd_ba], sd_addr[8:0]}); end
        4'b0100: begin last_rcd = cyc - act_cyc; wr_cyc = cyc; wr_base = int'({sd_ba, open_row[sd_ba], sd_addr[8:0]}); end
        4'b0010: if (sd_addr[10]) pre_all = 1;
        4'b0001: begin refs++; if (!pre_all) ref_bad++; end
        4'b0000: mrs_val = sd_addr;
        default: ;
      endcase
      if (cyc - rd_cyc >= exp_cl && cyc - rd_cyc <= exp_cl + 3)
        drv = sd_rd(rd_base + cyc - rd_cyc - exp_cl);
      if (cyc - wr_cyc >= 0 && cyc - wr_cyc <= 3)
        sdm[wr_base + cyc - wr_cyc] = merge(sd_rd(wr_base + cyc - wr_cyc), dq_out, sd_dqm);
      if (!rom_ce_n) begin
        if (!sd_cs_n) cs_viol++;
        if (!rom_oe_n) begin
          drv = rom_rd(int'(rom_addr)); oe_low++;
          if (dq_oe) bus_fight++;
        end
        if (!rom_we_n) begin
          rom[int'(rom_addr)] = merge(rom_rd(int'(rom_addr)), dq_out, sd_dqm); we_low++;
        end
      end
    end
    dq_in = drv;
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [23:0] wa, input logic [15:0] be,
                        input logic [127:0] wd, output bit err, output logic [127:0] rd);
    int guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_write = wr; req_addr = wa[23:2]; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 2000) begin @(negedge clk); guard++; end
    err = rsp_err; rd = rsp_rdata;
  endtask

  function automatic logic [31:0] pat(int a);
    return 32'hC3000000 ^ (32'(a) * 32'h0001_0101);
  endfunction

  task automatic t_init;
    int guard = 0;
    @(negedge clk);
    check(req_ready == 1'b0, "R1", "ready low after reset", 128'(req_ready), 128'h0);
    while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
    check(refs == 2 && ref_bad == 0, "R1", "init refreshes after precharge", 128'(refs), 128'd2);
    check(mrs_val[2:0] == 3'b010 && mrs_val[6:4] == 3'd2, "R1", "mode register value",
          128'(mrs_val), 128'h022);
  endtask

  task automatic t_sd_read(input logic [1:0] rcd, input bit cl, input logic [23:0] wa);
    bit err; logic [127:0] rd, exp;
    int off = int'(wa - cfg_base_start);
    int exp_rcd = (rcd == 0) ? 2 : (rcd == 1) ? 3 : 4;
    cfg_rcd = rcd; cfg_cl = cl; exp_cl = cl ? 3 : 2;
    for (int k = 0; k < 4; k++) begin
      sdm[off + k] = pat(off + k + 17 * int'(rcd));
      exp[32*k +: 32] = pat(off + k + 17 * int'(rcd));
    end
    do_req(1'b0, wa, 16'hFFFF, '0, err, rd);
    check(last_rcd == exp_rcd, "R3", "activate to read distance", 128'(last_rcd), 128'(exp_rcd));
    check(!err && rd == exp, "R4", "read burst data at programmed latency", rd, exp);
  endtask

  task automatic t_sd_write;
    bit err; logic [127:0] rd, wd, got, exp;
    int off = 24'h002208;
    logic [15:0] be = 16'hA5F1;
    wd = 128'h44444444_33333333_22222222_11111111 ^ 128'h0F0F;
    cfg_rcd = 2'd1; cfg_cl = 1'b1; exp_cl = 3;
    for (int k = 0; k < 4; k++) begin
      sdm[off + k] = pat(off + k);
      exp[32*k +: 32] = merge(pat(off + k), wd[32*k +: 32], ~be[4*k +: 4]);
    end
    do_req(1'b1, cfg_base_start + 24'(off), be, wd, err, rd);
    for (int k = 0; k < 4; k++) got[32*k +: 32] = sd_rd(off + k);
    check(!err && got == exp, "R5", "byte-merged write burst", got, exp);
    check(last_rcd == 3, "R3", "activate to write distance", 128'(last_rcd), 128'd3);
    do_req(1'b0, cfg_base_start + 24'(off), 16'hFFFF, '0, err, rd);
    check(rd == exp, "R6", "read back after precharge", rd, exp);
  endtask

  task automatic t_boot_read(input logic [3:0] w);
    bit err; logic [127:0] rd, exp;
    int o0 = oe_low, a0 = acts;
    cfg_boot_wait = w;
    for (int k = 0; k < 4; k++) begin
      rom[32 + k] = pat(900 + k + int'(w));
      exp[32*k +: 32] = pat(900 + k + int'(w));
    end
    do_req(1'b0, cfg_boot_start + 24'd32, 16'hFFFF, '0, err, rd);
    check(!err && rd == exp, "R8", "boot read data", rd, exp);
    check(oe_low - o0 == 4 * (int'(w) + 1) && acts == a0, "R8", "boot strobe cycles",
          128'(oe_low - o0), 128'(4 * (int'(w) + 1)));
  endtask

  task automatic t_boot_write_wp;
    bit err; logic [127:0] rd, wd, got, exp;
    int w0;
    wd = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    cfg_boot_wp = 1'b0; cfg_boot_wait = 4'd0;
    for (int k = 0; k < 4; k++) begin
      rom[64 + k] = 32'h5555_5555;
      exp[32*k +: 32] = merge(32'h5555_5555, wd[32*k +: 32], ~4'b0111);
    end
    do_req(1'b1, cfg_boot_start + 24'd64, 16'h7777, wd, err, rd);
    for (int k = 0; k < 4; k++) got[32*k +: 32] = rom_rd(64 + k);
    check(!err && got == exp, "R8", "boot write merged", got, exp);
    cfg_boot_wp = 1'b1;
    w0 = we_low;
    do_req(1'b1, cfg_boot_start + 24'd64, 16'hFFFF, ~wd, err, rd);
    for (int k = 0; k < 4; k++) got[32*k +: 32] = rom_rd(64 + k);
    check(err && we_low == w0, "R9", "protected write rejected", 128'(we_low - w0), 128'h0);
    check(got == exp, "R9", "protected contents unchanged", got, exp);
    do_req(1'b0, cfg_boot_start + 24'd64, 16'hFFFF, '0, err, rd);
    check(!err && rd == exp, "R9", "protected window still readable", rd, exp);
    cfg_boot_wp = 1'b0;
  endtask

  task automatic t_window;
    bit err; logic [127:0] rd;
    int a0, o0;
    cfg_base_start = 24'h000000; cfg_base_size = 24'hFFFFFF; cfg_boot_start = 24'hC00000;
    cfg_rcd = 2'd0; cfg_cl = 1'b0; exp_cl = 2;
    sdm[24'h7FFFFC] = 32'h0BADCAFE;
    do_req(1'b0, 24'h7FFFFC, 16'hFFFF, '0, err, rd);
    check(!err && rd[31:0] == 32'h0BADCAFE, "R2", "last word under 32 MB cap", 128'(rd[31:0]),
          128'h0BADCAFE);
    a0 = acts; o0 = oe_low;
    do_req(1'b0, 24'h800000, 16'hFFFF, '0, err, rd);
    check(err && acts == a0 && oe_low == o0, "R2", "first word past 32 MB cap rejected",
          128'(err), 128'h1);
    cfg_base_start = 24'h100000; cfg_base_size = 24'h400000; cfg_boot_start = 24'h800000;
    do_req(1'b1, 24'h600000, 16'hFFFF, '1, err, rd);
    check(err && acts == a0 && we_low >= 0, "R2", "address outside both windows", 128'(err), 128'h1);
  endtask

  task automatic t_refresh;
    bit err; logic [127:0] rd, exp;
    int r0;
    cfg_ref_int = 16'd40;
    repeat (5) @(negedge clk);
    r0 = refs;
    repeat (400) @(negedge clk);
    check(refs - r0 >= 9 && refs - r0 <= 11, "R7", "refresh count over 400 cycles",
          128'(refs - r0), 128'd10);
    cfg_rcd = 2'd2; cfg_cl = 1'b1; exp_cl = 3;
    for (int k = 0; k < 4; k++) begin sdm[24'h30 + k] = pat(k + 5); exp[32*k +: 32] = pat(k + 5); end
    for (int i = 0; i < 6; i++) begin
      do_req(1'b0, cfg_base_start + 24'h30, 16'hFFFF, '0, err, rd);
      check(!err && rd == exp, "R7", "read between refreshes", rd, exp);
    end
    check(ref_bad == 0, "R7", "every refresh after precharge-all", 128'(ref_bad), 128'h0);
    cfg_ref_int = 16'd3000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_init();
    t_sd_read(2'd0, 1'b0, 24'h112344);
    t_sd_read(2'd1, 1'b1, 24'h2A0010);
    t_sd_read(2'd3, 1'b0, 24'h4FFFF0);
    t_sd_write();
    t_boot_read(4'd0);
    t_boot_read(4'd3);
    t_boot_write_wp();
    t_window();
    t_refresh();
    check(cs_viol == 0, "R8", "SDRAM deselected during boot access", 128'(cs_viol), 128'h0);
    check(bus_fight == 0, "R10", "single data bus driver", 128'(bus_fight), 128'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule